// File: doc/BRIEF.md
# Pad attribute driver logic

This block sits between the core and the physical pads of a chip. It serves two groups of pads: a larger multiplexed group and a smaller dedicated group. For every pad, the core supplies an output value, an output enable and an attribute word. The block returns a pad drive value, a pad drive-enable and the core-side input level. The tristate buffer is shown as an enable rather than an inout, so the pad macro outside the block combines the drive value and the enable into the real pad.

Two attribute bits are used. Bit 0 inverts both the outgoing and the incoming data. Bit 1 selects open-drain mode: in this mode the pad is driven only when it should be low and is released otherwise. The remaining attribute bits are reserved and ignored. The clock pad and the active-low reset pad are wired straight through to the core. The data paths are purely combinational.

Top module: `pad_attr_driver`

## Requirements
- R1: For every pad, the core input equals the pad level XOR attribute bit 0 (bit 0 = 1 means inverted).
- R2: For every pad, the pad drive value always equals the core output XOR attribute bit 0. With output enable 1 and attribute bit 1 = 0, the drive-enable is 1.
- R3: With output enable 1, attribute bit 1 = 1 (open-drain) and an effective output (core output XOR bit 0) of 0, the drive-enable is 1 and the drive value is 0.
- R4: With attribute bit 1 = 1 and an effective output of 1, the drive-enable is 0, so the pad is never driven high.
- R5: With output enable 0, the drive-enable is 0 whatever the attribute.
- R6: Attribute bits above bit 1 have no effect on any output.
- R7: The core clock output follows the clock pad input, and the core reset output follows the active-low reset pad input.
- R8: The multiplexed group has 16 pads and the dedicated group has 8 pads. Each pad's outputs depend only on that pad's own inputs.
- R9: The core input changes only when the pad level or the attribute changes. The drive value changes only when the attribute or the core output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pad_i | input | 1 | Clock from the clock pad |
| rst_pad_ni | input | 1 | Active-low reset from the reset pad |
| clk_o | output | 1 | Core clock |
| rst_no | output | 1 | Core active-low reset |
| mux_out_i | input | 16 | Core output value per multiplexed pad |
| mux_oe_i | input | 16 | Output enable per multiplexed pad |
| mux_attr_i | input | 16x8 | Attribute word per multiplexed pad |
| mux_pad_i | input | 16 | Level seen on each multiplexed pad |
| mux_pad_o | output | 16 | Drive value per multiplexed pad |
| mux_pad_en_o | output | 16 | Drive-enable per multiplexed pad |
| mux_in_o | output | 16 | Core input per multiplexed pad |
| ded_out_i | input | 8 | Core output value per dedicated pad |
| ded_oe_i | input | 8 | Output enable per dedicated pad |
| ded_attr_i | input | 8x8 | Attribute word per dedicated pad |
| ded_pad_i | input | 8 | Level seen on each dedicated pad |
| ded_pad_o | output | 8 | Drive value per dedicated pad |
| ded_pad_en_o | output | 8 | Drive-enable per dedicated pad |
| ded_in_o | output | 8 | Core input per dedicated pad |

## Verification
The block holds no state, so any fault shows at the ports in the same cycle as the stimulus that exposes it. A wrong inversion or open-drain decode shows as a wrong drive value, enable or core input for that combination of attribute and data. A crossed index between pads shows only when neighbouring pads are given different settings, which is why the bench drives per-pad patterns that differ from pad to pad. A reserved bit that leaks into the logic shows when those bits are set while the low two bits are held.

// File: rtl/pad_attr_pkg.sv
package pad_attr_pkg;
  localparam int unsigned ATTR_W  = 8;
  localparam int unsigned INV_IDX = 0;
  localparam int unsigned OD_IDX  = 1;

  typedef struct packed {
    logic od;
    logic inv;
  } pad_mode_t;
endpackage

// File: rtl/pad_cell.sv
module pad_cell
  import pad_attr_pkg::*;
(
  input  pad_mode_t mode_i,
  input  logic      out_i,
  input  logic      oe_i,
  input  logic      pad_i,
  output logic      pad_o,
  output logic      pad_en_o,
  output logic      in_o
);
  logic eff_out;

  always_comb begin
    eff_out  = out_i ^ mode_i.inv;
    pad_o    = eff_out;
    pad_en_o = oe_i & (~mode_i.od | ~eff_out);
    in_o     = pad_i ^ mode_i.inv;
  end

  always_comb begin
    if (mode_i.od && pad_en_o) begin
      AST_OD_NEVER_HIGH: assert (!pad_o); // R4
    end
    if (!oe_i) begin
      AST_OFF_NO_DRIVE: assert (!pad_en_o); // R5
    end
    if (oe_i && !mode_i.od) begin
      AST_PUSH_PULL_DRIVES: assert (pad_en_o); // R2
    end
  end
endmodule

// File: rtl/pad_group.sv
module pad_group
  import pad_attr_pkg::*;
#(
  parameter int unsigned NUM_PADS = 8,
  parameter int unsigned AW       = ATTR_W
) (
  input  logic [NUM_PADS-1:0]         out_i,
  input  logic [NUM_PADS-1:0]         oe_i,
  input  logic [NUM_PADS-1:0][AW-1:0] attr_i,
  input  logic [NUM_PADS-1:0]         pad_i,
  output logic [NUM_PADS-1:0]         pad_o,
  output logic [NUM_PADS-1:0]         pad_en_o,
  output logic [NUM_PADS-1:0]         in_o
);
  for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
    pad_mode_t mode;
    logic      unused_rsvd;

    assign mode.inv    = attr_i[g][INV_IDX];
    assign mode.od     = attr_i[g][OD_IDX];
    assign unused_rsvd = ^attr_i[g][AW-1:2];

    pad_cell u_cell (
      .mode_i   (mode),
      .out_i    (out_i[g]),
      .oe_i     (oe_i[g]),
      .pad_i    (pad_i[g]),
      .pad_o    (pad_o[g]),
      .pad_en_o (pad_en_o[g]),
      .in_o     (in_o[g])
    );
  end
endmodule

// File: rtl/pad_attr_driver.sv
module pad_attr_driver
  import pad_attr_pkg::*;
#(
  parameter int unsigned NUM_MUX = 16,
  parameter int unsigned NUM_DED = 8,
  parameter int unsigned AW      = ATTR_W
) (
  input  logic                       clk_pad_i,
  input  logic                       rst_pad_ni,
  output logic                       clk_o,
  output logic                       rst_no,
  input  logic [NUM_MUX-1:0]         mux_out_i,
  input  logic [NUM_MUX-1:0]         mux_oe_i,
  input  logic [NUM_MUX-1:0][AW-1:0] mux_attr_i,
  input  logic [NUM_MUX-1:0]         mux_pad_i,
  output logic [NUM_MUX-1:0]         mux_pad_o,
  output logic [NUM_MUX-1:0]         mux_pad_en_o,
  output logic [NUM_MUX-1:0]         mux_in_o,
  input  logic [NUM_DED-1:0]         ded_out_i,
  input  logic [NUM_DED-1:0]         ded_oe_i,
  input  logic [NUM_DED-1:0][AW-1:0] ded_attr_i,
  input  logic [NUM_DED-1:0]         ded_pad_i,
  output logic [NUM_DED-1:0]         ded_pad_o,
  output logic [NUM_DED-1:0]         ded_pad_en_o,
  output logic [NUM_DED-1:0]         ded_in_o
);
  assign clk_o  = clk_pad_i;
  assign rst_no = rst_pad_ni;

  pad_group #(.NUM_PADS(NUM_MUX), .AW(AW)) u_mux_group (
    .out_i    (mux_out_i),
    .oe_i     (mux_oe_i),
    .attr_i   (mux_attr_i),
    .pad_i    (mux_pad_i),
    .pad_o    (mux_pad_o),
    .pad_en_o (mux_pad_en_o),
    .in_o     (mux_in_o)
  );

  pad_group #(.NUM_PADS(NUM_DED), .AW(AW)) u_ded_group (
    .out_i    (ded_out_i),
    .oe_i     (ded_oe_i),
    .attr_i   (ded_attr_i),
    .pad_i    (ded_pad_i),
    .pad_o    (ded_pad_o),
    .pad_en_o (ded_pad_en_o),
    .in_o     (ded_in_o)
  );

  AST_MUX_IN_CAUSE: assert property (@(posedge clk_pad_i) disable iff (!rst_pad_ni)
    !$stable(mux_in_o) |-> (!$stable(mux_pad_i) || !$stable(mux_attr_i))); // R9
  AST_DED_IN_CAUSE: assert property (@(posedge clk_pad_i) disable iff (!rst_pad_ni)
    !$stable(ded_in_o) |-> (!$stable(ded_pad_i) || !$stable(ded_attr_i))); // R9
  AST_MUX_DRV_CAUSE: assert property (@(posedge clk_pad_i) disable iff (!rst_pad_ni)
    !$stable(mux_pad_o) |-> (!$stable(mux_out_i) || !$stable(mux_attr_i))); // R9
  AST_DED_DRV_CAUSE: assert property (@(posedge clk_pad_i) disable iff (!rst_pad_ni)
    !$stable(ded_pad_o) |-> (!$stable(ded_out_i) || !$stable(ded_attr_i))); // R9
endmodule

// File: tb/tb_pad_attr_driver.sv
module tb_pad_attr_driver;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NM = 16;
  localparam int unsigned ND = 8;
  localparam int unsigned AW = 8;
  localparam int unsigned NVEC = 12;

  // {oe, out, od, inv, pad, exp_drv, exp_en, exp_in}
  localparam logic [7:0] VEC [NVEC] = '{
    8'b1_0_0_0_0_0_1_0,
    8'b1_1_0_0_1_1_1_1,
    8'b1_1_0_1_1_0_1_0,
    8'b1_0_0_1_0_1_1_1,
    8'b1_0_1_0_0_0_1_0,
    8'b1_1_1_0_1_1_0_1,
    8'b1_1_1_1_0_0_1_1,
    8'b1_0_1_1_1_1_0_0,
    8'b0_1_0_0_0_1_0_0,
    8'b0_0_1_1_1_1_0_0,
    8'b0_0_0_0_1_0_0_1,
    8'b0_1_1_0_1_1_0_1
  };

  logic clk, rst_n, clk_o, rst_no;
  logic [NM-1:0] mux_out, mux_oe, mux_pad, mux_pad_o, mux_en, mux_in;
  logic [NM-1:0][AW-1:0] mux_attr;
  logic [ND-1:0] ded_out, ded_oe, ded_pad, ded_pad_o, ded_en, ded_in;
  logic [ND-1:0][AW-1:0] ded_attr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  pad_attr_driver dut (
    .clk_pad_i(clk), .rst_pad_ni(rst_n), .clk_o(clk_o), .rst_no(rst_no),
    .mux_out_i(mux_out), .mux_oe_i(mux_oe), .mux_attr_i(mux_attr), .mux_pad_i(mux_pad),
    .mux_pad_o(mux_pad_o), .mux_pad_en_o(mux_en), .mux_in_o(mux_in),
    .ded_out_i(ded_out), .ded_oe_i(ded_oe), .ded_attr_i(ded_attr), .ded_pad_i(ded_pad),
    .ded_pad_o(ded_pad_o), .ded_pad_en_o(ded_en), .ded_in_o(ded_in)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_all(input logic oe, input logic out, input logic [AW-1:0] attr,
                           input logic pad);
    @(negedge clk);
    mux_oe = {NM{oe}}; mux_out = {NM{out}}; mux_pad = {NM{pad}};
    ded_oe = {ND{oe}}; ded_out = {ND{out}}; ded_pad = {ND{pad}};
    for (int k = 0; k < NM; k++) mux_attr[k] = attr;
    for (int k = 0; k < ND; k++) ded_attr[k] = attr;
    #1;
  endtask

  initial begin
    rst_n = 1'b0;
    mux_out = '0; mux_oe = '0; mux_pad = '0; mux_attr = '0;
    ded_out = '0; ded_oe = '0; ded_pad = '0; ded_attr = '0;
    @(negedge clk); #1;
    // R7 reset passthrough while low, R5 nothing driven at reset state
    check("R7 rst low", 64'(rst_no), 64'd0);
    check("R5 reset state mux en", 64'(mux_en), 64'd0);
    check("R5 reset state ded en", 64'(ded_en), 64'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R7 rst high", 64'(rst_no), 64'd1);
    // R7 clock passthrough, both phases
    @(posedge clk); #1;
    check("R7 clk high", 64'(clk_o), 64'd1);
    @(negedge clk); #1;
    check("R7 clk low", 64'(clk_o), 64'd0);

    // Table walk: R1..R5, applied to every pad of both groups
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] e;
      e = VEC[v];
      apply_all(e[7], e[6], {6'b0, e[5], e[4]}, e[3]);
      check($sformatf("R1 R2 R3 R4 R5 mux drv vec%0d", v), 64'(mux_pad_o), 64'({NM{e[2]}}));
      check($sformatf("R2 R3 R4 R5 mux en vec%0d", v), 64'(mux_en), 64'({NM{e[1]}}));
      check($sformatf("R1 mux in vec%0d", v), 64'(mux_in), 64'({NM{e[0]}}));
      check($sformatf("R2 ded drv vec%0d", v), 64'(ded_pad_o), 64'({ND{e[2]}}));
      check($sformatf("R3 R4 R5 ded en vec%0d", v), 64'(ded_en), 64'({ND{e[1]}}));
      check($sformatf("R1 ded in vec%0d", v), 64'(ded_in), 64'({ND{e[0]}}));
    end

    // R6: reserved bits set, results must match the low-bit behaviour
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] e;
      e = VEC[v];
      apply_all(e[7], e[6], {6'b101101, e[5], e[4]}, e[3]);
      check($sformatf("R6 mux vec%0d", v), 64'({mux_pad_o, mux_en, mux_in}),
            64'({{NM{e[2]}}, {NM{e[1]}}, {NM{e[0]}}}));
      check($sformatf("R6 ded vec%0d", v), 64'({ded_pad_o, ded_en, ded_in}),
            64'({{ND{e[2]}}, {ND{e[1]}}, {ND{e[0]}}}));
    end

    // R8: distinct settings per pad, no cross-talk
    @(negedge clk);
    for (int k = 0; k < NM; k++) begin
      logic [3:0] kk;
      kk = 4'(k);
      mux_oe[k] = ~kk[3]; mux_out[k] = kk[2]; mux_pad[k] = kk[0] ^ kk[3];
      mux_attr[k] = {6'b0, kk[1], kk[0]};
    end
    for (int k = 0; k < ND; k++) begin
      logic [2:0] kk;
      kk = 3'(k);
      ded_oe[k] = 1'b1; ded_out[k] = kk[0]; ded_pad[k] = kk[2];
      ded_attr[k] = {6'b0, kk[2], kk[1]};
    end
    #1;
    for (int k = 0; k < NM; k++) begin
      logic [3:0] kk;
      logic eff;
      kk = 4'(k);
      eff = kk[2] ^ kk[0];
      check($sformatf("R8 mux pad%0d", k), 64'({mux_pad_o[k], mux_en[k], mux_in[k]}),
            64'({eff, ~kk[3] & (~kk[1] | ~eff), kk[3]}));
    end
    for (int k = 0; k < ND; k++) begin
      logic [2:0] kk;
      logic eff;
      kk = 3'(k);
      eff = kk[0] ^ kk[1];
      check($sformatf("R8 ded pad%0d", k), 64'({ded_pad_o[k], ded_en[k], ded_in[k]}),
            64'({eff, ~kk[2] | ~eff, kk[2] ^ kk[1]}));
    end

    // R9: changing output and enable leaves core input alone
    apply_all(1'b1, 1'b0, 8'h01, 1'b1);
    check("R9 in before", 64'({mux_in, ded_in}), 64'd0);
    @(negedge clk);
    mux_out = '1; mux_oe = '0; ded_out = '1; ded_oe = '0;
    #1;
    check("R9 in after out/oe change", 64'({mux_in, ded_in}), 64'd0);
    // R9: changing pad level and enable leaves drive value alone
    @(negedge clk);
    mux_pad = '0; mux_oe = '1; ded_pad = '0; ded_oe = '1;
    #1;
    check("R9 drv after pad/oe change", 64'({mux_pad_o, ded_pad_o}), 64'd0);

    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule